// File: doc/BRIEF.md
# DSP RAM Host Indirect-Access Port

This block gives a host processor a three-register window onto a DSP's two private memories. The code store holds 64 words of 12 bits and the data store holds 32 words of 16 bits. The host writes an address/direction latch and then moves one word through either the code port or the data port. Each port takes the word as one 16-bit transfer or as two 8-bit transfers. Writing the latch again re-arms the port for the next word. The DSP sees the stores through its own read ports and one write port.

Host traffic into the stores is gated by DSP state. While the DSP runs freely, the host cannot read or write either store. When the DSP is halted in step mode, host access is allowed again. In step mode, DSP writes aimed at the DAC or the record FIFO are also written into the data store location under them, so the host can inspect them.

Top module: `dsp_ram_host_port`

## Requirements
- R1: A host write with `hostSel`=0 loads the latch. Bit 7 is the direction (1 = the next port transfer is a read, 0 = a write), bits 5:0 are the address, and the held low byte is cleared to zero. The write arms the port. After reset the port is unarmed and the address is 0, so port accesses are ignored until the latch is written.
- R2: A 16-bit write to the code port (`hostSel`=1) stores bits 11:0 of the word. Reading the code port returns that value with bits 15:12 zero. Read data appears on `hostRdata` in the cycle after the read strobe. `hostRdata` is zero in every other cycle.
- R3: A 16-bit write to the data port (`hostSel`=2) stores all 16 bits, and a 16-bit read returns them.
- R4: With `hostByte`=1, the byte lane is taken from `hostWdata[7:0]`. A low-lane write (`hostHi`=0) only holds the byte. A high-lane write commits {high, held low}. An 8-bit read returns the byte selected by `hostHi` in bits 7:0, with bits 15:8 zero.
- R5: A completed word transfer disarms the port. This is a 16-bit access, or the high lane of an 8-bit access. Further port accesses are then ignored until the latch is written again.
- R6: A port write while the latch says read is ignored. A port read while the latch says write returns zero. Neither access changes any state.
- R7: While `dspRun`=1 and `dspStep`=0, port reads and writes are ignored. Reads return zero, and the arm, held byte and stores are unchanged.
- R8: While `dspRun`=1 and `dspStep`=1, host port access works as when the DSP is stopped.
- R9: A data port access whose latched address exceeds 0x1F is ignored and returns zero. The code port accepts 0x00 to 0x3F.
- R10: A DSP write (`dspWrDest` 0 = data store, 1 = DAC, 2 = record FIFO, 3 = none) always stores when the destination is the data store. It stores at `dspWrAddr` for DAC or FIFO only while `dspStep`=1. `dspRdData` and `dspCodeData` follow their addresses combinationally.
- R11: When a DSP write and a host data-port write commit in the same cycle, the DSP write is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostSel | input | 2 | 0 latch, 1 code port, 2 data port |
| hostByte | input | 1 | 1 = 8-bit access |
| hostHi | input | 1 | Byte lane for 8-bit access (1 = high) |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Registered host read data |
| dspRun | input | 1 | DSP running |
| dspStep | input | 1 | DSP halted in step mode |
| dspWrEn | input | 1 | DSP write strobe |
| dspWrDest | input | 2 | DSP write destination |
| dspWrAddr | input | 5 | DSP write address in data store |
| dspWrData | input | 16 | DSP write value |
| dspRdAddr | input | 5 | DSP data store read address |
| dspRdData | output | 16 | DSP data store read value |
| dspCodeAddr | input | 6 | DSP code fetch address |
| dspCodeData | output | 12 | DSP code word |

## Verification
The hardest cases to reach from the ports involve several pieces of state at once. One is a blocked or wrong-direction access arriving mid-word, after a low byte is held and while the port is still armed. Another is a DSP write colliding with a host commit. The bench reaches these with seeded random sequences that mix latch writes, byte-lane choices and random run/step states against a bench model of the arm, direction and held byte. Directed steps cover the collision and the step-mode capture of DAC and FIFO writes.

// File: rtl/dsp_ram_port_pkg.sv
package dsp_ram_port_pkg;
  parameter int CODE_AW = 6;
  parameter int CODE_DW = 12;
  parameter int DATA_AW = 5;
  parameter int WORD_W  = 16;
  parameter int BYTE_W  = 8;
  parameter int ADDR_W  = (CODE_AW > DATA_AW) ? CODE_AW : DATA_AW;
  parameter int DIR_BIT = 7;

  typedef enum logic [1:0] {SEL_LATCH = 2'd0, SEL_CODE = 2'd1, SEL_DATA = 2'd2, SEL_NONE = 2'd3} hostSel_e;
  typedef enum logic [1:0] {DST_DATA = 2'd0, DST_DAC = 2'd1, DST_FIFO = 2'd2, DST_NONE = 2'd3} dspDest_e;

  typedef struct packed {
    logic              codeWe;
    logic              dataWe;
    logic              rdCode;
    logic              rdData;
    logic              rdByte;
    logic              rdHi;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] word;
  } portStrobe_t;
endpackage

// File: rtl/dsp_ram_port_ctrl.sv
module dsp_ram_port_ctrl
  import dsp_ram_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [1:0]        hostSel,
  input  logic              hostByte,
  input  logic              hostHi,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic              dspRun,
  input  logic              dspStep,
  output portStrobe_t       st
);
  logic              armed;
  logic              dirRd;
  logic [ADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0] lowHold;

  logic latchWr, hostOk, portSel, addrOk, access, wrAcc, rdAcc, lastPart;

  always_comb begin
    latchWr  = hostWr && (hostSel == SEL_LATCH);
    hostOk   = !dspRun || dspStep;
    portSel  = (hostSel == SEL_CODE) || (hostSel == SEL_DATA);
    addrOk   = (hostSel == SEL_CODE) || (addrQ[ADDR_W-1:DATA_AW] == '0);
    access   = portSel && armed && hostOk && addrOk;
    wrAcc    = hostWr && access && !dirRd;
    rdAcc    = hostRd && !hostWr && access && dirRd;
    lastPart = !hostByte || hostHi;

    st        = '0;
    st.addr   = addrQ;
    st.word   = hostByte ? {hostWdata[BYTE_W-1:0], lowHold} : hostWdata;
    st.codeWe = wrAcc && lastPart && (hostSel == SEL_CODE);
    st.dataWe = wrAcc && lastPart && (hostSel == SEL_DATA);
    st.rdCode = rdAcc && (hostSel == SEL_CODE);
    st.rdData = rdAcc && (hostSel == SEL_DATA);
    st.rdByte = hostByte;
    st.rdHi   = hostHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      dirRd   <= 1'b0;
      addrQ   <= '0;
      lowHold <= '0;
    end else if (latchWr) begin
      armed   <= 1'b1;
      dirRd   <= hostWdata[DIR_BIT];
      addrQ   <= hostWdata[ADDR_W-1:0];
      lowHold <= '0;
    end else begin
      if (wrAcc && !lastPart) lowHold <= hostWdata[BYTE_W-1:0];
      if ((wrAcc || rdAcc) && lastPart) armed <= 1'b0;
    end
  end

  // R1: latch write arms the port and captures the direction bit
  assert_latch_arm_R1: assert property (@(posedge clk) disable iff (!rstN)
    latchWr |=> (armed && dirRd == $past(hostWdata[DIR_BIT])));

  // R7: free-running DSP locks out every port strobe
  assert_locked_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dspRun && !dspStep) |-> !(st.codeWe || st.dataWe || st.rdCode || st.rdData));

  // R7: a locked-out port access leaves arm and held byte alone
  assert_blocked_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dspRun && !dspStep && !latchWr) |=> ($stable(armed) && $stable(lowHold)));

  // R5: a finished word transfer leaves the port disarmed
  assert_disarm_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((st.codeWe || st.dataWe) && !latchWr) |=> !armed);

  // R6: a port in read direction never produces a write strobe
  assert_dir_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    dirRd |-> !(st.codeWe || st.dataWe));
endmodule

// File: rtl/dsp_ram_port_dpath.sv
module dsp_ram_port_dpath
  import dsp_ram_port_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  portStrobe_t        st,
  input  logic               dspStep,
  input  logic               dspWrEn,
  input  logic [1:0]         dspWrDest,
  input  logic [DATA_AW-1:0] dspWrAddr,
  input  logic [WORD_W-1:0]  dspWrData,
  input  logic [DATA_AW-1:0] dspRdAddr,
  output logic [WORD_W-1:0]  dspRdData,
  input  logic [CODE_AW-1:0] dspCodeAddr,
  output logic [CODE_DW-1:0] dspCodeData,
  output logic [WORD_W-1:0]  hostRdata
);
  localparam int CODE_DEPTH = 1 << CODE_AW;
  localparam int DATA_DEPTH = 1 << DATA_AW;
  localparam int PAD_W      = WORD_W - CODE_DW;

  logic [CODE_DW-1:0] codeMem [CODE_DEPTH];
  logic [WORD_W-1:0]  dataMem [DATA_DEPTH];

  logic              dspWe;
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] rdOut;

  always_comb begin
    dspWe = dspWrEn && ((dspWrDest == DST_DATA) ||
            (dspStep && ((dspWrDest == DST_DAC) || (dspWrDest == DST_FIFO))));
    rdWord = st.rdCode ? {{PAD_W{1'b0}}, codeMem[st.addr[CODE_AW-1:0]]}
                       : dataMem[st.addr[DATA_AW-1:0]];
    if (st.rdByte)
      rdOut = {{(WORD_W-BYTE_W){1'b0}}, st.rdHi ? rdWord[WORD_W-1:BYTE_W] : rdWord[BYTE_W-1:0]};
    else
      rdOut = rdWord;
    dspRdData   = dataMem[dspRdAddr];
    dspCodeData = codeMem[dspCodeAddr];
  end

  always_ff @(posedge clk) begin
    if (dspWe) dataMem[dspWrAddr] <= dspWrData;
    else if (st.dataWe) dataMem[st.addr[DATA_AW-1:0]] <= st.word;
  end

  always_ff @(posedge clk) begin
    if (st.codeWe) codeMem[st.addr[CODE_AW-1:0]] <= st.word[CODE_DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdata <= '0;
    else hostRdata <= (st.rdCode || st.rdData) ? rdOut : '0;
  end

  // R2: code words read back with the upper bits clear
  assert_code_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(st.rdCode) |-> (hostRdata[WORD_W-1:CODE_DW] == '0));

  // R4: byte reads occupy only the low lane
  assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past((st.rdCode || st.rdData) && st.rdByte) |-> (hostRdata[WORD_W-1:BYTE_W] == '0));

  // R7: no accepted read strobe means zero read data
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.rdCode || st.rdData) |-> (hostRdata == '0));

  // R10 R11: a qualifying DSP write always lands
  assert_dsp_store_R10: assert property (@(posedge clk) disable iff (!rstN)
    dspWe |=> (dataMem[$past(dspWrAddr)] == $past(dspWrData)));
endmodule

// File: rtl/dsp_ram_host_port.sv
module dsp_ram_host_port
  import dsp_ram_port_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic [1:0]         hostSel,
  input  logic               hostByte,
  input  logic               hostHi,
  input  logic [WORD_W-1:0]  hostWdata,
  output logic [WORD_W-1:0]  hostRdata,
  input  logic               dspRun,
  input  logic               dspStep,
  input  logic               dspWrEn,
  input  logic [1:0]         dspWrDest,
  input  logic [DATA_AW-1:0] dspWrAddr,
  input  logic [WORD_W-1:0]  dspWrData,
  input  logic [DATA_AW-1:0] dspRdAddr,
  output logic [WORD_W-1:0]  dspRdData,
  input  logic [CODE_AW-1:0] dspCodeAddr,
  output logic [CODE_DW-1:0] dspCodeData
);
  portStrobe_t st;

  dsp_ram_port_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostByte(hostByte), .hostHi(hostHi), .hostWdata(hostWdata),
    .dspRun(dspRun), .dspStep(dspStep), .st(st)
  );

  dsp_ram_port_dpath dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .dspStep(dspStep),
    .dspWrEn(dspWrEn), .dspWrDest(dspWrDest), .dspWrAddr(dspWrAddr), .dspWrData(dspWrData),
    .dspRdAddr(dspRdAddr), .dspRdData(dspRdData),
    .dspCodeAddr(dspCodeAddr), .dspCodeData(dspCodeData), .hostRdata(hostRdata)
  );
endmodule

// File: tb/dsp_ram_host_port_tb.sv
module dsp_ram_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWr, hostRd, hostByte, hostHi;
  logic [1:0]  hostSel;
  logic [15:0] hostWdata, hostRdata;
  logic        dspRun, dspStep, dspWrEn;
  logic [1:0]  dspWrDest;
  logic [4:0]  dspWrAddr, dspRdAddr;
  logic [15:0] dspWrData, dspRdData;
  logic [5:0]  dspCodeAddr;
  logic [11:0] dspCodeData;

  int total = 0;
  int fails = 0;

  // bench model
  logic [11:0] codeM [64];
  logic [15:0] dataM [32];
  logic        mArmed, mDir;
  logic [5:0]  mAddr;
  logic [7:0]  mHold;

  always #5 clk = ~clk;

  dsp_ram_host_port dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostByte(hostByte), .hostHi(hostHi), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .dspRun(dspRun), .dspStep(dspStep), .dspWrEn(dspWrEn), .dspWrDest(dspWrDest),
    .dspWrAddr(dspWrAddr), .dspWrData(dspWrData), .dspRdAddr(dspRdAddr), .dspRdData(dspRdData),
    .dspCodeAddr(dspCodeAddr), .dspCodeData(dspCodeData)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [15:0] readWord(input logic [1:0] sel, input logic [5:0] a);
    if (sel == 2'd1) return {4'h0, codeM[a]};
    return dataM[a[4:0]];
  endfunction

  // model of one host operation; returns expected read data
  task automatic model(input logic wr, input logic rd, input logic [1:0] sel, input logic bm,
                       input logic hi, input logic [15:0] w, input logic run, input logic step,
                       output logic [15:0] exp);
    logic ok, acc;
    logic [15:0] word;
    exp = 16'h0;
    ok  = !run || step;
    acc = mArmed && ok && (sel == 2'd1 || (sel == 2'd2 && !mAddr[5]));
    if (wr && sel == 2'd0) begin
      mAddr = w[5:0]; mDir = w[7]; mArmed = 1'b1; mHold = 8'h0;
    end else if (wr && acc && !mDir) begin
      if (bm && !hi) mHold = w[7:0];
      else begin
        word = bm ? {w[7:0], mHold} : w;
        if (sel == 2'd1) codeM[mAddr] = word[11:0];
        else dataM[mAddr[4:0]] = word;
        mArmed = 1'b0;
      end
    end else if (rd && !wr && acc && mDir) begin
      word = readWord(sel, mAddr);
      exp  = bm ? {8'h0, hi ? word[15:8] : word[7:0]} : word;
      if (!bm || hi) mArmed = 1'b0;
    end
  endtask

  task automatic doOp(input logic wr, input logic rd, input logic [1:0] sel, input logic bm,
                      input logic hi, input logic [15:0] w, input logic run, input logic step,
                      input string tag);
    logic [15:0] exp;
    model(wr, rd, sel, bm, hi, w, run, step, exp);
    hostWr = wr; hostRd = rd; hostSel = sel; hostByte = bm; hostHi = hi; hostWdata = w;
    dspRun = run; dspStep = step;
    @(posedge clk);
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    if (rd) check(tag, hostRdata, exp);
  endtask

  task automatic latch(input logic rdDir, input logic [5:0] a);
    doOp(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, {8'h0, rdDir, 1'b0, a}, 1'b0, 1'b0, "R1");
  endtask

  task automatic dspCheck(input string tag, input logic [4:0] a);
    dspRdAddr = a;
    #1;
    check(tag, dspRdData, dataM[a]);
  endtask

  task automatic dspWrite(input logic [1:0] dest, input logic [4:0] a, input logic [15:0] d,
                          input logic step);
    dspWrEn = 1'b1; dspWrDest = dest; dspWrAddr = a; dspWrData = d; dspStep = step; dspRun = 1'b1;
    if (dest == 2'd0 || (step && (dest == 2'd1 || dest == 2'd2))) dataM[a] = d;
    @(posedge clk);
    @(negedge clk);
    dspWrEn = 1'b0; dspRun = 1'b0; dspStep = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] exp;
    void'($urandom(32'd2718));
    rstN = 1'b0; hostWr = 0; hostRd = 0; hostSel = 0; hostByte = 0; hostHi = 0; hostWdata = 0;
    dspRun = 0; dspStep = 0; dspWrEn = 0; dspWrDest = 2'd3; dspWrAddr = 0; dspWrData = 0;
    dspRdAddr = 0; dspCodeAddr = 0;
    mArmed = 0; mDir = 0; mAddr = 0; mHold = 0;
    for (int i = 0; i < 64; i++) codeM[i] = '0;
    for (int i = 0; i < 32; i++) dataM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset rdata", hostRdata, 16'h0);

    // load code store with 16-bit writes that carry junk upper bits (R2)
    for (int i = 0; i < 64; i++) begin
      latch(1'b0, 6'(i));
      doOp(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 16'hF000 | 16'((i * 37 + 5) & 12'hFFF), 0, 0, "R2");
    end
    // load data store, odd locations through byte lanes (R3 R4)
    for (int i = 0; i < 32; i++) begin
      v = 16'(i * 16'h0101) ^ 16'h5A3C;
      latch(1'b0, 6'(i));
      if (i % 2 == 1) begin
        doOp(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, {8'h0, v[7:0]}, 0, 0, "R4");
        doOp(1'b1, 1'b0, 2'd2, 1'b1, 1'b1, {8'h0, v[15:8]}, 0, 0, "R4");
      end else
        doOp(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, v, 0, 0, "R3");
    end

    // R2 code readback, upper nibble zero
    latch(1'b1, 6'd9);
    doOp(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 0, 0, 0, "R2 code read");
    check("R2 code literal", {4'h0, codeM[9]}, 16'h0000 | 16'((9 * 37 + 5) & 12'hFFF));
    dspCodeAddr = 6'd63; #1;
    check("R2 code fetch", {4'h0, dspCodeData}, {4'h0, codeM[63]});
    // R3 word readback
    latch(1'b1, 6'd4);
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 0, "R3 data read");
    // R4 byte reads of a byte-written word
    latch(1'b1, 6'd7);
    doOp(1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 0, 0, 0, "R4 low byte read");
    doOp(1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 0, 0, 0, "R4 high byte read");
    dspCheck("R4 byte commit", 5'd7);

    // R5 second word without re-latching is ignored
    latch(1'b0, 6'd5);
    doOp(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 16'h1111, 0, 0, "R5");
    doOp(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 16'h2222, 0, 0, "R5");
    dspCheck("R5 second write ignored", 5'd5);
    check("R5 literal", dataM[5], 16'h1111);
    latch(1'b1, 6'd5);
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 0, "R5 first read");
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 0, "R5 read after disarm");

    // R6 direction mismatch
    latch(1'b1, 6'd6);
    doOp(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 16'hDEAD, 0, 0, "R6");
    dspCheck("R6 write in read dir ignored", 5'd6);
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 0, "R6 read still armed");
    latch(1'b0, 6'd6);
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 0, "R6 read in write dir");

    // R7 lockout while running; arm survives
    latch(1'b0, 6'd8);
    doOp(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 16'h00AB, 0, 0, "R7");
    doOp(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 16'h00CD, 1, 0, "R7");
    doOp(1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 16'h00EF, 1, 0, "R7");
    dspCheck("R7 blocked write", 5'd8);
    doOp(1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 16'h0012, 0, 0, "R7");
    dspCheck("R7 held byte kept", 5'd8);
    check("R7 literal", dataM[8], 16'h12AB);
    latch(1'b1, 6'd8);
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 1, 0, "R7 blocked read zero");
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 0, "R7 arm preserved");

    // R8 step-mode access
    latch(1'b0, 6'd10);
    doOp(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 16'hBEEF, 1, 1, "R8");
    latch(1'b1, 6'd10);
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 1, 1, "R8 step read");

    // R9 data address range
    latch(1'b0, 6'h25);
    doOp(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 16'h7777, 0, 0, "R9");
    dspCheck("R9 alias untouched", 5'd5);
    latch(1'b1, 6'h25);
    doOp(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 0, "R9 out of range read");
    doOp(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 0, 0, 0, "R9 code high address");

    // R10 DSP writes and step-mode capture
    dspWrite(2'd0, 5'd12, 16'hA5A5, 1'b0);
    dspCheck("R10 data dest", 5'd12);
    dspWrite(2'd1, 5'd13, 16'h1234, 1'b0);
    dspCheck("R10 DAC not captured", 5'd13);
    dspWrite(2'd2, 5'd14, 16'h4321, 1'b1);
    dspCheck("R10 FIFO captured in step", 5'd14);
    dspWrite(2'd1, 5'd15, 16'h0F0F, 1'b1);
    dspCheck("R10 DAC captured in step", 5'd15);
    dspWrite(2'd3, 5'd16, 16'hFFFF, 1'b1);
    dspCheck("R10 no dest", 5'd16);

    // R11 collision: DSP write wins
    latch(1'b0, 6'd20);
    model(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 16'h1111, 1'b1, 1'b1, exp);
    dataM[20] = 16'h9999;
    hostWr = 1; hostSel = 2'd2; hostByte = 0; hostWdata = 16'h1111; dspRun = 1; dspStep = 1;
    dspWrEn = 1; dspWrDest = 2'd0; dspWrAddr = 5'd20; dspWrData = 16'h9999;
    @(posedge clk); @(negedge clk);
    hostWr = 0; dspWrEn = 0; dspRun = 0; dspStep = 0;
    dspCheck("R11 DSP priority", 5'd20);

    // seeded random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0]  r;
      logic [1:0]  sel;
      logic        wr, rd, bm, hi, run, step;
      logic [15:0] w;
      string       tag;
      r    = 4'($urandom);
      sel  = (r < 4) ? 2'd0 : ((r[0]) ? 2'd1 : 2'd2);
      wr   = (sel == 2'd0) ? 1'b1 : 1'($urandom);
      rd   = !wr;
      bm   = 1'($urandom);
      hi   = 1'($urandom);
      w    = 16'($urandom);
      if (sel == 2'd0) w[5] = ($urandom % 8 == 0);
      run  = ($urandom % 4 == 0);
      step = 1'($urandom);
      tag  = (run && !step) ? "R7 random" : (sel == 2'd1 ? "R2 random" : "R3 random");
      doOp(wr, rd, sel, bm, hi, w, run, step, tag);
    end
    for (int i = 0; i < 32; i++) dspCheck("R3 random final", 5'(i));

    summary();
    $finish;
  end
endmodule